// File: doc/BRIEF.md
# Register-file push-all / pop-all sequencer

This block saves the eight general-purpose registers of a small register file onto a stack memory, or restores them from it, one word per step. A single-cycle `start` pulse begins a sequence. `pop_sel` chooses the direction and is sampled only on that edge. The block owns the stack-pointer register. It reaches the register file through a plain index/read/write port and drives a synchronous single-port stack RAM through word address, write data and write enable.

The registers are indexed 0 to 7 in the usual order of the general register file: AX=0, CX=1, DX=2, BX=3, SP=4, BP=5, SI=6, DI=7. A push sequence walks the indices upward. A pop sequence walks them downward. Slot 4 stands for the stack pointer. A push stores there the value the stack pointer had when the sequence was accepted. A pop reads that word and throws it away, so the running stack pointer alone decides where the pointer ends. The register width `XLEN` is 16 or 32, and each transfer moves the pointer by `XLEN/8` bytes.

States: `S_IDLE` waits for `start`. `S_IDLE`→`S_PUSH` is taken on start with `pop_sel`=0, and `S_IDLE`→`S_POP_RD` on start with `pop_sel`=1. `S_PUSH` performs one write per cycle, stays there for steps 0 to 6, and goes `S_PUSH`→`S_DONE` after step 7. `S_POP_RD` presents the read address and always goes to `S_POP_WR`. `S_POP_WR` writes the register and goes back to `S_POP_RD`, or to `S_DONE` after the eighth word. `S_DONE` raises `done` for one cycle and always returns to `S_IDLE`.

Top module: `regfile_stack_seq`

## Requirements
- R1: After reset the stack pointer equals `SP_INIT` (default 0x0200), and `busy` and `done` are 0. No write enable is active while the block is idle.
- R2: Every push step first lowers the stack pointer by `XLEN/8` and then writes one word at the lowered address. After a push-all the pointer is 8·`XLEN/8` below its start value.
- R3: Push-all writes register indices 0,1,2,3,4,5,6,7 in that order, on consecutive cycles. Index 0 (AX) therefore lands at the highest address and index 7 (DI) at the lowest.
- R4: The word stored for index 4 (SP) is the stack-pointer value held when `start` was accepted, not the live register-file entry and not the running pointer.
- R5: Pop-all reads the word at the current pointer, writes it to the register file, and then raises the pointer by `XLEN/8`. It visits indices 7,6,5,4,3,2,1,0. Index 4 is never written: that register-file entry keeps its value.
- R6: After a pop-all that follows a matching push-all, every register and the stack pointer hold the values they had before the push-all. This also holds for two nested push-alls undone by two pop-alls.
- R7: `done` is high for exactly one cycle. If `start` is sampled at clock edge E0, `done` is high in the cycle after edge E0+8 for a push-all and after edge E0+16 for a pop-all. The pop-all takes two cycles per word because the RAM read data arrives one cycle after the address.
- R8: A `start` while `busy` is high, including the `done` cycle, is ignored. It changes neither the running sequence, nor the stack contents, nor the pointer, and no new sequence follows.
- R9: `mem_addr` is the stack-pointer byte address divided by `XLEN/8`, keeping the low `MAW` bits (default 8).
- R10: `pop_sel` is sampled only at the accepted `start` edge. Changing it later does not alter the direction of the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (accepted only when idle) |
| pop_sel | input | 1 | 0 = push-all, 1 = pop-all, sampled with start |
| busy | output | 1 | Sequence in progress, including the done cycle |
| done | output | 1 | One-cycle end-of-sequence pulse |
| rf_addr | output | 3 | Register-file index |
| rf_rdata | input | XLEN | Register-file read data for rf_addr (combinational) |
| rf_wdata | output | XLEN | Register-file write data |
| rf_we | output | 1 | Register-file write enable |
| mem_addr | output | MAW | Stack RAM word address |
| mem_wdata | output | XLEN | Stack RAM write data |
| mem_we | output | 1 | Stack RAM write enable |
| mem_rdata | input | XLEN | Stack RAM read data, one cycle after the address |
| sp_o | output | XLEN | Current stack-pointer value |

## Verification
Two pairs of events can fall in the same cycle. The first is a new `start` arriving while a sequence steps, or in the very cycle that `done` is high. The second is the SP slot of a push coinciding with a stack pointer that has already moved. The bench injects a start pulse of the opposite direction mid-way through a push-all, and another one in the done cycle. It judges both by the unchanged completion cycle, the stack words, the final pointer, and `busy` falling one cycle later. A nested push-all starts from a lowered pointer, so a design that stores the live pointer or the start value of the earlier push in slot 4 is caught by the stored word.

// File: rtl/rss_pkg.sv
package rss_pkg;
    localparam int NREG     = 8;
    localparam int IDX_W    = $clog2(NREG);
    localparam logic [IDX_W-1:0] SP_INDEX = IDX_W'(4);

    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH,
        S_POP_RD,
        S_POP_WR,
        S_DONE
    } rss_state_e;
endpackage

// File: rtl/rss_step_ctr.sv
module rss_step_ctr
    import rss_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             adv,
    input  logic             dir_pop,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    logic [IDX_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= cnt_q + IDX_W'(1);
        end
    end

    // Upward walk for push, downward walk for pop
    assign idx  = dir_pop ? IDX_W'(NREG - 1) - cnt_q : cnt_q;
    assign last = (cnt_q == IDX_W'(NREG - 1));

    a_r3_count_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clear && !last) |=> (cnt_q == $past(cnt_q) + IDX_W'(1)));
endmodule

// File: rtl/rss_sp_unit.sv
module rss_sp_unit #(
    parameter int          XLEN    = 16,
    parameter logic [31:0] SP_INIT = 32'h0000_0200
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            snap_en,
    input  logic            dec,
    input  logic            inc,
    output logic [XLEN-1:0] sp_q,
    output logic [XLEN-1:0] sp_dec,
    output logic [XLEN-1:0] snap_q
);
    localparam int STEP = XLEN / 8;

    logic [XLEN-1:0] step_v;

    generate
        if (XLEN == 32) begin : g_w32
            assign step_v = 32'd4;
        end else begin : g_w16
            assign step_v = XLEN'(STEP);
        end
    endgenerate

    assign sp_dec = sp_q - step_v;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= SP_INIT[XLEN-1:0];
        end else if (dec) begin
            sp_q <= sp_dec;
        end else if (inc) begin
            sp_q <= sp_q + step_v;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (snap_en) begin
            snap_q <= sp_q;
        end
    end

    a_r2_no_dual_step: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec && inc));
    a_r4_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_en |=> $stable(snap_q));
endmodule

// File: rtl/regfile_stack_seq.sv
module regfile_stack_seq
    import rss_pkg::*;
#(
    parameter int          XLEN    = 16,
    parameter int          MAW     = 8,
    parameter logic [31:0] SP_INIT = 32'h0000_0200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             pop_sel,
    output logic             busy,
    output logic             done,
    output logic [2:0]       rf_addr,
    input  logic [XLEN-1:0]  rf_rdata,
    output logic [XLEN-1:0]  rf_wdata,
    output logic             rf_we,
    output logic [MAW-1:0]   mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    output logic             mem_we,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic [XLEN-1:0]  sp_o
);
    localparam int STEP = XLEN / 8;
    localparam int BSH  = $clog2(STEP);

    rss_state_e       state_q, state_d;
    logic             dir_q;
    logic             accept;
    logic             ctr_clear, ctr_adv, ctr_last;
    logic [IDX_W-1:0] idx;
    logic             sp_dec_en, sp_inc_en;
    logic [XLEN-1:0]  sp_q, sp_dec, snap_q;

    assign accept = (state_q == S_IDLE) && start;

    rss_step_ctr u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ctr_clear),
        .adv     (ctr_adv),
        .dir_pop (dir_q),
        .idx     (idx),
        .last    (ctr_last)
    );

    rss_sp_unit #(.XLEN(XLEN), .SP_INIT(SP_INIT)) u_sp (
        .clk     (clk),
        .rst_n   (rst_n),
        .snap_en (accept),
        .dec     (sp_dec_en),
        .inc     (sp_inc_en),
        .sp_q    (sp_q),
        .sp_dec  (sp_dec),
        .snap_q  (snap_q)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                dir_q <= pop_sel;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = pop_sel ? S_POP_RD : S_PUSH;
            S_PUSH:   if (ctr_last) state_d = S_DONE;
            S_POP_RD: state_d = S_POP_WR;
            S_POP_WR: state_d = ctr_last ? S_DONE : S_POP_RD;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rf_addr   = 3'(idx);
        rf_wdata  = mem_rdata;
        rf_we     = 1'b0;
        mem_addr  = sp_q[BSH +: MAW];
        mem_wdata = '0;
        mem_we    = 1'b0;
        sp_dec_en = 1'b0;
        sp_inc_en = 1'b0;
        ctr_clear = accept;
        ctr_adv   = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                busy = 1'b0;
            end
            S_PUSH: begin
                mem_addr  = sp_dec[BSH +: MAW];
                mem_wdata = (idx == SP_INDEX) ? snap_q : rf_rdata;
                mem_we    = 1'b1;
                sp_dec_en = 1'b1;
                ctr_adv   = 1'b1;
            end
            S_POP_RD: begin
                mem_addr = sp_q[BSH +: MAW];
            end
            S_POP_WR: begin
                rf_we     = (idx != SP_INDEX);
                sp_inc_en = 1'b1;
                ctr_adv   = 1'b1;
            end
            S_DONE: begin
                done = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    assign sp_o = sp_q;

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !rf_we));
    a_r2_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp_o == $past(sp_o) - XLEN'(STEP)));
    a_r5_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_POP_WR) |=> (sp_o == $past(sp_o) + XLEN'(STEP)));
    a_r5_sp_slot_skip: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_addr != 3'(SP_INDEX)));
    a_r5_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && rf_we));
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);
    a_r8_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    a_r10_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(dir_q));
endmodule

// File: tb/sim_regfile_stack_seq.sv
`timescale 1ns/1ps
module sim_regfile_stack_seq;
    localparam int XLEN = 16;
    localparam int MAW  = 8;
    localparam int STEP = XLEN / 8;
    localparam logic [15:0] SP0 = 16'h0200;
    localparam int NV = 3;
    localparam logic [15:0] VEC [NV][8] = '{
        '{16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'hDEAD, 16'h6666, 16'h7777, 16'h8888},
        '{16'hA5A5, 16'h0001, 16'hFFFF, 16'h8000, 16'hBEEF, 16'h7FFF, 16'h00FF, 16'hFF00},
        '{16'h0000, 16'h1234, 16'h5678, 16'h9ABC, 16'h0F0F, 16'hDEF0, 16'hC3C3, 16'h3C3C}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic pop_sel = 1'b0;
    logic busy, done, rf_we, mem_we;
    logic [2:0] rf_addr;
    logic [XLEN-1:0] rf_rdata, rf_wdata, mem_wdata, sp_o;
    logic [XLEN-1:0] mem_rdata = '0;
    logic [MAW-1:0] mem_addr;
    logic [XLEN-1:0] rf [8];
    logic [XLEN-1:0] mem [256];
    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    regfile_stack_seq #(.XLEN(XLEN), .MAW(MAW), .SP_INIT(32'(SP0))) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .pop_sel(pop_sel),
        .busy(busy), .done(done), .rf_addr(rf_addr), .rf_rdata(rf_rdata),
        .rf_wdata(rf_wdata), .rf_we(rf_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata), .sp_o(sp_o)
    );

    assign rf_rdata = rf[rf_addr];

    always @(posedge clk) begin
        if (rf_we) rf[rf_addr] <= rf_wdata;
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // Run one sequence; inj_mid > 0 pulses an opposite start at that cycle,
    // inj_done pulses start in the done cycle. Returns cycles to done.
    task automatic run_op(input logic pop, input int inj_mid, input bit inj_done, output int n);
        @(negedge clk);
        start = 1'b1;
        pop_sel = pop;
        n = 0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            start = 1'b0;
            pop_sel = ~pop;                       // R10: direction change after start
            n = k;
            if (k == inj_mid) start = 1'b1;
            if (done) begin
                if (inj_done) start = 1'b1;
                break;
            end
        end
        @(negedge clk);
        start = 1'b0;
        chk("R8 busy falls after done", 32'(busy), 32'd0);
    endtask

    task automatic load_regs(input int v);
        @(negedge clk);
        for (int i = 0; i < 8; i++) rf[i] <= VEC[v][i];
    endtask

    task automatic clobber_regs();
        @(negedge clk);
        for (int i = 0; i < 8; i++) rf[i] <= 16'h5A00 | 16'(i);
    endtask

    task automatic check_stack(input logic [15:0] s0, input int v);
        for (int k = 0; k < 8; k++) begin
            logic [15:0] a;
            logic [15:0] e;
            a = (s0 - 16'(STEP * (k + 1))) >> 1;
            e = (k == 4) ? s0 : VEC[v][k];
            chk((k == 4) ? "R4 SP slot holds snapshot" : "R3 push order/R2 address R9",
                32'(mem[a[MAW-1:0]]), 32'(e));
        end
    endtask

    task automatic check_regs(input int v);
        for (int i = 0; i < 8; i++) begin
            if (i == 4) chk("R5 SP slot not written", 32'(rf[4]), 32'(16'h5A04));
            else chk("R6 register restored", 32'(rf[i]), 32'(VEC[v][i]));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        int n;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int i = 0; i < 8; i++) rf[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset sp", 32'(sp_o), 32'(SP0));
        chk("R1 reset busy", 32'(busy), 32'd0);
        chk("R1 reset done", 32'(done), 32'd0);
        chk("R1 reset no writes", 32'({mem_we, rf_we}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle sp", 32'(sp_o), 32'(SP0));

        // Table-driven push/pop round trips
        for (int v = 0; v < NV; v++) begin
            load_regs(v);
            run_op(1'b0, 0, 1'b0, n);
            chk("R7 push done cycle", 32'(n), 32'd9);
            chk("R2 sp after push R9", 32'(sp_o), 32'(SP0 - 16'(8 * STEP)));
            check_stack(SP0, v);
            clobber_regs();
            run_op(1'b1, 0, 1'b0, n);
            chk("R7 pop done cycle", 32'(n), 32'd17);
            chk("R6 sp after pop", 32'(sp_o), 32'(SP0));
            check_regs(v);
        end

        // Nested push-alls: second snapshot is the lowered pointer
        load_regs(0);
        run_op(1'b0, 0, 1'b0, n);
        load_regs(1);
        run_op(1'b0, 0, 1'b0, n);
        chk("R2 sp after nested push", 32'(sp_o), 32'(SP0 - 16'(16 * STEP)));
        check_stack(SP0 - 16'(8 * STEP), 1);
        check_stack(SP0, 0);
        clobber_regs();
        run_op(1'b1, 0, 1'b0, n);
        chk("R6 sp after first pop", 32'(sp_o), 32'(SP0 - 16'(8 * STEP)));
        check_regs(1);
        clobber_regs();
        run_op(1'b1, 0, 1'b0, n);
        chk("R6 sp after second pop", 32'(sp_o), 32'(SP0));
        check_regs(0);

        // Start ignored mid-sequence and in done cycle
        load_regs(2);
        run_op(1'b0, 3, 1'b1, n);
        chk("R8 push done cycle with stray starts", 32'(n), 32'd9);
        chk("R8 sp with stray starts", 32'(sp_o), 32'(SP0 - 16'(8 * STEP)));
        check_stack(SP0, 2);
        repeat (4) @(negedge clk);
        chk("R8 no new sequence busy", 32'(busy), 32'd0);
        chk("R8 no new sequence sp", 32'(sp_o), 32'(SP0 - 16'(8 * STEP)));
        clobber_regs();
        run_op(1'b1, 5, 1'b1, n);
        chk("R8 pop done cycle with stray starts R10", 32'(n), 32'd17);
        chk("R8 sp after pop with stray starts", 32'(sp_o), 32'(SP0));
        check_regs(2);
        repeat (3) @(negedge clk);
        chk("R8 idle after stray done start", 32'(busy), 32'd0);

        summary();
    end
endmodule